// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block carries out one nonvolatile memory operation each time it sees a start pulse. Four operations exist: programming a single word from a data input, programming a full row of words fetched one by one from SRAM, erasing one page, and erasing every page of the program area. Each word or page goes to the flash array as one command on a valid/ready port. Row data comes from an SRAM read port that has a valid/ready request channel and a one-beat response channel.

Before it touches the array, the sequencer checks the target against write-protect inputs. Each program-area page has its own protect bit. All boot-region pages share one protect bit. A page that lies in neither region is always refused. While an operation runs, the block holds busy, which the CPU uses as its stall. It defers sleep until the operation ends. It reports done, an error flag and a low-voltage error flag, and it raises an interrupt flag that stays set until software clears it.

Back-pressure: once a command or read request is presented, valid stays high and the payload stays unchanged until ready is seen high at a clock edge. The array lowers ready while it is working, and no further command is issued until ready returns. SRAM responses are never back-pressured, because at most one read is outstanding.

Top module: `nvm_seq`

## Requirements
- R1: After reset, busy, done, err, lv_err, irq_flag, fl_valid and sram_req_valid are all 0.
- R2: Op code 1 (word program) issues exactly one array command with fl_erase=0, fl_addr equal to tgt_addr with its two byte-offset bits dropped, and fl_wdata equal to wr_data.
- R3: Op code 3 (row program) issues 128 program commands. Word i goes to row base + i, where the row base is tgt_addr with bits 8:0 ignored. Its data is the SRAM word read from src_addr + 4*i. The SRAM reads are issued in ascending order, one per command.
- R4: Op code 4 (page erase) issues one erase command at the page base, with tgt_addr bits 11:0 ignored, provided the selected page is not protected.
- R5: Op code 5 (program-area erase) ignores tgt_addr. It issues one erase per program-area page, in ascending order from page 0, and never touches a boot page. It is refused when any bit of wp_prog is set.
- R6: For codes 1, 3 and 4, a page in the boot region (pages 128 to 131 by default) is guarded by wp_boot. A page in the program area (pages 0 to 15) is guarded by its own wp_prog bit. A page in neither region is refused.
- R7: A refused operation makes no array command and no SRAM request, sets err, and still ends with a done pulse.
- R8: Any op code other than 1, 3, 4 and 5 is a no-op. It makes no array or SRAM access and completes with done, with err=0 and lv_err=0, which clears any earlier error.
- R9: If low_volt is high in any cycle while the block is reading or commanding, lv_err and err are set. The command in flight is finished and no further command follows.
- R10: irq_flag rises in the cycle after done and stays high until irq_clr. A done in the same cycle as irq_clr wins.
- R11: fl_valid and sram_req_valid, together with their payloads, hold steady until accepted.
- R12: sleep_grant follows sleep_req only while not busy. A start while busy is ignored.
- R13: busy is high from the cycle after an accepted start through the one-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| op_code | input | 4 | Operation select (1 word, 3 row, 4 page erase, 5 area erase) |
| tgt_addr | input | ADDR_W | Flash byte address |
| wr_data | input | WORD_W | Data for word program |
| src_addr | input | SRAM_AW | SRAM byte address of row data |
| wp_prog | input | PFM_PAGES | Per-page program-area protect |
| wp_boot | input | 1 | Shared boot-region protect |
| low_volt | input | 1 | Low supply indication |
| sleep_req | input | 1 | Sleep request |
| irq_clr | input | 1 | Clears the interrupt flag |
| busy | output | 1 | Operation in progress, stall |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation did not finish normally |
| lv_err | output | 1 | Low voltage seen during operation |
| irq_flag | output | 1 | Sticky completion flag |
| sleep_grant | output | 1 | Sleep may proceed |
| fl_valid | output | 1 | Array command valid |
| fl_ready | input | 1 | Array can take a command |
| fl_erase | output | 1 | 1 = page erase, 0 = word program |
| fl_addr | output | ADDR_W-2 | Array word address |
| fl_wdata | output | WORD_W | Program data |
| sram_req_valid | output | 1 | SRAM read request valid |
| sram_req_ready | input | 1 | SRAM accepts request |
| sram_addr | output | SRAM_AW | SRAM byte address |
| sram_rvalid | input | 1 | SRAM read data valid |
| sram_rdata | input | WORD_W | SRAM read data |

## Verification
The bench builds the block with its default parameters: 32-bit words, 128-word rows, 8-row pages, a 20-bit flash address, 16 program pages and 4 boot pages from page 128. These sizes give a full 128-word row and a 16-page area erase within a short run. A page index of 8 bits can reach the boot region, the program area and the gap between them. The array model lowers ready for several cycles after each erase, and the SRAM model toggles its ready every cycle, so both hold rules are exercised.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  localparam logic [3:0] OPC_WORD = 4'd1;
  localparam logic [3:0] OPC_ROW  = 4'd3;
  localparam logic [3:0] OPC_PAGE = 4'd4;
  localparam logic [3:0] OPC_AREA = 4'd5;

  typedef enum logic [2:0] {
    K_NONE, K_WORD, K_ROW, K_PAGE, K_AREA
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RD_REQ, S_RD_WAIT, S_WR_CMD, S_DRAIN, S_FIN
  } seq_state_e;

  function automatic op_kind_e decode_op(input logic [3:0] code);
    case (code)
      OPC_WORD: return K_WORD;
      OPC_ROW:  return K_ROW;
      OPC_PAGE: return K_PAGE;
      OPC_AREA: return K_AREA;
      default:  return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/nvm_prot_chk.sv
module nvm_prot_chk
  import nvm_seq_pkg::*;
#(
  parameter int PG_W       = 8,
  parameter int PFM_PAGES  = 16,
  parameter int BOOT_FIRST = 128,
  parameter int BOOT_PAGES = 4
) (
  input  op_kind_e              kind,
  input  logic [PG_W-1:0]       page_idx,
  input  logic [PFM_PAGES-1:0]  wp_prog,
  input  logic                  wp_boot,
  output logic                  deny
);
  localparam logic [PG_W:0] PFM_END  = (PG_W+1)'(PFM_PAGES);
  localparam logic [PG_W:0] BOOT_LO  = (PG_W+1)'(BOOT_FIRST);
  localparam logic [PG_W:0] BOOT_END = (PG_W+1)'(BOOT_FIRST + BOOT_PAGES);

  logic [PG_W:0] idx_x;
  logic          in_pfm, in_boot, page_bit;

  assign idx_x   = {1'b0, page_idx};
  assign in_pfm  = idx_x < PFM_END;
  assign in_boot = (idx_x >= BOOT_LO) && (idx_x < BOOT_END);

  always_comb begin
    page_bit = 1'b0;
    for (int p = 0; p < PFM_PAGES; p++) begin
      if (page_idx == PG_W'(p)) page_bit = wp_prog[p];
    end
  end

  always_comb begin
    case (kind)
      K_AREA:                deny = |wp_prog;
      K_WORD, K_ROW, K_PAGE: deny = in_pfm ? page_bit : (in_boot ? wp_boot : 1'b1);
      default:               deny = 1'b0;
    endcase
  end
endmodule

// File: rtl/nvm_addr_gen.sv
module nvm_addr_gen
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SRAM_AW   = 16,
  parameter int BYTE_B    = 2,
  parameter int ROW_WORDS = 128,
  parameter int PAGE_ROWS = 8,
  parameter int CNT_W     = 8,
  localparam int FA_W     = ADDR_W - BYTE_B,
  localparam int RW_B     = $clog2(ROW_WORDS),
  localparam int PG_B     = RW_B + $clog2(PAGE_ROWS),
  localparam int PG_W     = FA_W - PG_B
) (
  input  op_kind_e             kind,
  input  logic [ADDR_W-1:0]    tgt_addr,
  input  logic [SRAM_AW-1:0]   src_addr,
  input  logic [CNT_W-1:0]     cnt,
  output logic [FA_W-1:0]      fl_addr,
  output logic [SRAM_AW-1:0]   sram_addr,
  output logic [PG_W-1:0]      page_idx
);
  logic [FA_W-1:0]           word_addr, row_base, page_base, area_base;
  logic [SRAM_AW-BYTE_B-1:0] src_word;
  logic                      unused_low;

  assign unused_low = ^{tgt_addr[BYTE_B-1:0], src_addr[BYTE_B-1:0]};
  assign word_addr  = tgt_addr[ADDR_W-1:BYTE_B];
  assign row_base   = {word_addr[FA_W-1:RW_B], {RW_B{1'b0}}};
  assign page_base  = {word_addr[FA_W-1:PG_B], {PG_B{1'b0}}};
  assign area_base  = FA_W'(cnt) << PG_B;
  assign page_idx   = word_addr[FA_W-1:PG_B];

  always_comb begin
    case (kind)
      K_ROW:   fl_addr = row_base | FA_W'(cnt);
      K_PAGE:  fl_addr = page_base;
      K_AREA:  fl_addr = area_base;
      default: fl_addr = word_addr;
    endcase
  end

  assign src_word  = src_addr[SRAM_AW-1:BYTE_B] + (SRAM_AW-BYTE_B)'(cnt);
  assign sram_addr = {src_word, {BYTE_B{1'b0}}};
endmodule

// File: rtl/nvm_irq_sleep.sv
module nvm_irq_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic irq_clr,
  input  logic busy,
  input  logic sleep_req,
  output logic irq_flag,
  output logic sleep_grant
);
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (done)    irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign sleep_grant = sleep_req & ~busy;
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SRAM_AW    = 16,
  parameter int WORD_W     = 32,
  parameter int ROW_WORDS  = 128,
  parameter int PAGE_ROWS  = 8,
  parameter int PFM_PAGES  = 16,
  parameter int BOOT_FIRST = 128,
  parameter int BOOT_PAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [3:0]            op_code,
  input  logic [ADDR_W-1:0]     tgt_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [SRAM_AW-1:0]    src_addr,
  input  logic [PFM_PAGES-1:0]  wp_prog,
  input  logic                  wp_boot,
  input  logic                  low_volt,
  input  logic                  sleep_req,
  input  logic                  irq_clr,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  lv_err,
  output logic                  irq_flag,
  output logic                  sleep_grant,
  output logic                  fl_valid,
  input  logic                  fl_ready,
  output logic                  fl_erase,
  output logic [ADDR_W-3:0]     fl_addr,
  output logic [WORD_W-1:0]     fl_wdata,
  output logic                  sram_req_valid,
  input  logic                  sram_req_ready,
  output logic [SRAM_AW-1:0]    sram_addr,
  input  logic                  sram_rvalid,
  input  logic [WORD_W-1:0]     sram_rdata
);
  localparam int BYTE_B = $clog2(WORD_W / 8);
  localparam int MAXC   = (ROW_WORDS > PFM_PAGES) ? ROW_WORDS : PFM_PAGES;
  localparam int CNT_W  = $clog2(MAXC) + 1;
  localparam int RW_B   = $clog2(ROW_WORDS);
  localparam int PG_B   = RW_B + $clog2(PAGE_ROWS);
  localparam int PG_W   = ADDR_W - BYTE_B - PG_B;
  localparam logic [CNT_W-1:0] ROW_LAST  = CNT_W'(ROW_WORDS - 1);
  localparam logic [CNT_W-1:0] AREA_LAST = CNT_W'(PFM_PAGES - 1);

  seq_state_e           state_q;
  op_kind_e             kind_q;
  logic [ADDR_W-1:0]    tgt_q;
  logic [SRAM_AW-1:0]   src_q;
  logic [WORD_W-1:0]    data_q;
  logic [CNT_W-1:0]     cnt_q, last_cnt;
  logic                 err_q, lv_q;
  logic [PG_W-1:0]      page_idx;
  logic                 deny, accessing, fl_fire, stop_now;

  nvm_addr_gen #(
    .ADDR_W(ADDR_W), .SRAM_AW(SRAM_AW), .BYTE_B(BYTE_B),
    .ROW_WORDS(ROW_WORDS), .PAGE_ROWS(PAGE_ROWS), .CNT_W(CNT_W)
  ) u_addr (
    .kind(kind_q), .tgt_addr(tgt_q), .src_addr(src_q), .cnt(cnt_q),
    .fl_addr(fl_addr), .sram_addr(sram_addr), .page_idx(page_idx)
  );

  nvm_prot_chk #(
    .PG_W(PG_W), .PFM_PAGES(PFM_PAGES),
    .BOOT_FIRST(BOOT_FIRST), .BOOT_PAGES(BOOT_PAGES)
  ) u_prot (
    .kind(kind_q), .page_idx(page_idx), .wp_prog(wp_prog),
    .wp_boot(wp_boot), .deny(deny)
  );

  nvm_irq_sleep u_irq (
    .clk(clk), .rst_n(rst_n), .done(done), .irq_clr(irq_clr),
    .busy(busy), .sleep_req(sleep_req),
    .irq_flag(irq_flag), .sleep_grant(sleep_grant)
  );

  assign busy           = (state_q != S_IDLE);
  assign done           = (state_q == S_FIN);
  assign err            = err_q;
  assign lv_err         = lv_q;
  assign fl_valid       = (state_q == S_WR_CMD);
  assign sram_req_valid = (state_q == S_RD_REQ);
  assign fl_erase       = (kind_q == K_PAGE) || (kind_q == K_AREA);
  assign fl_wdata       = data_q;
  assign fl_fire        = fl_valid && fl_ready;
  assign accessing      = (state_q == S_RD_REQ) || (state_q == S_RD_WAIT) ||
                          (state_q == S_WR_CMD) || (state_q == S_DRAIN);

  always_comb begin
    case (kind_q)
      K_ROW:   last_cnt = ROW_LAST;
      K_AREA:  last_cnt = AREA_LAST;
      default: last_cnt = '0;
    endcase
  end

  assign stop_now = (cnt_q == last_cnt) || lv_q || low_volt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      tgt_q   <= '0;
      src_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      lv_q    <= 1'b0;
    end else begin
      if (accessing && low_volt) begin
        lv_q  <= 1'b1;
        err_q <= 1'b1;
      end
      case (state_q)
        S_IDLE: begin
          if (start) begin
            kind_q  <= decode_op(op_code);
            tgt_q   <= tgt_addr;
            src_q   <= src_addr;
            data_q  <= wr_data;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            lv_q    <= 1'b0;
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (kind_q == K_NONE) begin
            state_q <= S_FIN;
          end else if (deny) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else if (kind_q == K_ROW) begin
            state_q <= S_RD_REQ;
          end else begin
            state_q <= S_WR_CMD;
          end
        end
        S_RD_REQ: begin
          if (sram_req_ready) state_q <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (sram_rvalid) begin
            data_q  <= sram_rdata;
            state_q <= S_WR_CMD;
          end
        end
        S_WR_CMD: begin
          if (fl_fire) begin
            if (stop_now) begin
              state_q <= S_DRAIN;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= (kind_q == K_ROW) ? S_RD_REQ : S_WR_CMD;
            end
          end
        end
        S_DRAIN: begin
          if (fl_ready) state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_seq_sva.sv
module nvm_seq_sva #(
  parameter int FA_W    = 18,
  parameter int SRAM_AW = 16,
  parameter int WORD_W  = 32,
  parameter int PG_B    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              lv_err,
  input logic              irq_flag,
  input logic              sleep_grant,
  input logic              fl_valid,
  input logic              fl_ready,
  input logic              fl_erase,
  input logic [FA_W-1:0]   fl_addr,
  input logic [WORD_W-1:0] fl_wdata,
  input logic              sram_req_valid,
  input logic              sram_req_ready,
  input logic [SRAM_AW-1:0] sram_addr
);
  p_fl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_addr) && $stable(fl_wdata) && $stable(fl_erase));

  p_sram_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req_valid && !sram_req_ready |=> sram_req_valid && $stable(sram_addr));

  p_no_sleep_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sleep_grant);

  p_done_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_irq_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_flag);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_valid && !sram_req_valid);

  p_lv_implies_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lv_err |-> err);

  p_erase_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_erase |-> fl_addr[PG_B-1:0] == '0);
endmodule

bind nvm_seq nvm_seq_sva #(
  .FA_W(ADDR_W - 2), .SRAM_AW(SRAM_AW), .WORD_W(WORD_W), .PG_B(PG_B)
) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .lv_err(lv_err), .irq_flag(irq_flag), .sleep_grant(sleep_grant),
  .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_erase(fl_erase),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata), .sram_req_valid(sram_req_valid),
  .sram_req_ready(sram_req_ready), .sram_addr(sram_addr)
);

// File: tb/nvm_seq_tb.sv
`timescale 1ns/1ps
module nvm_seq_tb;
  localparam int ADDR_W = 20;
  localparam int SRAM_AW = 16;
  localparam int FA_W = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [ADDR_W-1:0] tgt_addr = '0;
  logic [31:0] wr_data = '0;
  logic [SRAM_AW-1:0] src_addr = '0;
  logic [15:0] wp_prog = '0;
  logic wp_boot = 1'b0, low_volt = 1'b0, sleep_req = 1'b0, irq_clr = 1'b0;
  logic busy, done, err, lv_err, irq_flag, sleep_grant;
  logic fl_valid, fl_ready, fl_erase;
  logic [FA_W-1:0] fl_addr;
  logic [31:0] fl_wdata;
  logic sram_req_valid, sram_req_ready, sram_rvalid;
  logic [SRAM_AW-1:0] sram_addr;
  logic [31:0] sram_rdata;

  always #2.5 clk = ~clk;

  nvm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .tgt_addr(tgt_addr), .wr_data(wr_data), .src_addr(src_addr),
    .wp_prog(wp_prog), .wp_boot(wp_boot), .low_volt(low_volt),
    .sleep_req(sleep_req), .irq_clr(irq_clr), .busy(busy), .done(done),
    .err(err), .lv_err(lv_err), .irq_flag(irq_flag), .sleep_grant(sleep_grant),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .sram_req_valid(sram_req_valid),
    .sram_req_ready(sram_req_ready), .sram_addr(sram_addr),
    .sram_rvalid(sram_rvalid), .sram_rdata(sram_rdata)
  );

  // array model: ready drops while a command is being worked on
  int fl_wait = 0;
  int fl_n = 0;
  logic [FA_W-1:0] lg_addr [0:1023];
  logic [31:0]     lg_data [0:1023];
  logic            lg_er   [0:1023];
  assign fl_ready = (fl_wait == 0);

  always @(posedge clk) begin
    if (fl_valid && fl_ready) begin
      lg_addr[fl_n] <= fl_addr;
      lg_data[fl_n] <= fl_wdata;
      lg_er[fl_n]   <= fl_erase;
      fl_n          <= fl_n + 1;
      fl_wait       <= fl_erase ? 4 : 1;
    end else if (fl_wait != 0) begin
      fl_wait <= fl_wait - 1;
    end
  end

  // SRAM model: ready toggles, data one cycle after request
  logic sr_tog = 1'b0;
  int sr_n = 0;
  logic [SRAM_AW-1:0] lg_sa [0:1023];
  assign sram_req_ready = sr_tog;
  always @(posedge clk) begin
    sr_tog <= ~sr_tog;
    if (sram_req_valid && sram_req_ready) begin
      sram_rvalid <= 1'b1;
      sram_rdata  <= {16'h5AC3, sram_addr};
      lg_sa[sr_n] <= sram_addr;
      sr_n        <= sr_n + 1;
    end else begin
      sram_rvalid <= 1'b0;
    end
  end

  // hold monitor for back-pressure
  int hold_n = 0, hold_bad = 0;
  logic fpend = 1'b0, spend = 1'b0;
  logic [FA_W-1:0] fpa; logic [31:0] fpd; logic [SRAM_AW-1:0] spa;
  always @(posedge clk) begin
    if (fpend) begin
      hold_n <= hold_n + 1;
      if (!(fl_valid && fl_addr == fpa && fl_wdata == fpd)) hold_bad <= hold_bad + 1;
    end
    if (spend) begin
      hold_n <= hold_n + 1;
      if (!(sram_req_valid && sram_addr == spa)) hold_bad <= hold_bad + 1;
    end
    fpend <= fl_valid && !fl_ready;
    fpa <= fl_addr; fpd <= fl_wdata;
    spend <= sram_req_valid && !sram_req_ready;
    spa <= sram_addr;
  end

  int checks = 0, fails = 0;
  int fl0, sr0;
  logic got_err, got_lv, busy_early;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic [SRAM_AW-1:0] s);
    int n;
    @(negedge clk);
    fl0 = fl_n; sr0 = sr_n;
    op_code = op; tgt_addr = a; wr_data = d; src_addr = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_early = busy;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R13", "completion", {63'd0, done}, 64'd1);
    got_err = err; got_lv = lv_err;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !lv_err, "R1", "status after reset",
        {busy, done, err, lv_err}, 0);
    chk(!irq_flag && !fl_valid && !sram_req_valid, "R1", "strobes after reset",
        {irq_flag, fl_valid, sram_req_valid}, 0);
  endtask

  task automatic t_word();
    run_op(4'd1, 20'h01236, 32'hDEADBEEF, '0);
    chk(busy_early === 1'b1, "R13", "busy after start", {63'd0, busy_early}, 1);
    chk(fl_n - fl0 == 1 && sr_n == sr0, "R2", "word cmd count", fl_n - fl0, 1);
    chk(lg_addr[fl0] == 18'h048D && lg_data[fl0] == 32'hDEADBEEF && !lg_er[fl0] && !got_err,
        "R2", "word addr/data", {lg_addr[fl0], lg_data[fl0]}, {18'h048D, 32'hDEADBEEF});
    @(negedge clk);
    chk(irq_flag === 1'b1, "R10", "irq after done", {63'd0, irq_flag}, 1);
    repeat (3) @(negedge clk);
    chk(irq_flag === 1'b1, "R10", "irq sticky", {63'd0, irq_flag}, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(irq_flag === 1'b0, "R10", "irq cleared", {63'd0, irq_flag}, 0);
  endtask

  task automatic t_row();
    int bad;
    fork
      run_op(4'd3, 20'h023FC, 32'h0, 16'h0104);
      begin
        repeat (20) @(negedge clk);
        sleep_req = 1'b1;
        #0.1;
        chk(busy && !sleep_grant, "R12", "sleep held while busy", {62'd0, busy, sleep_grant}, 2);
        op_code = 4'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(fl_n - fl0 == 128 && sr_n - sr0 == 128, "R3", "row cmd count", fl_n - fl0, 128);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      if (lg_addr[fl0+i] != FA_W'(18'h0880 + i) || lg_er[fl0+i]) bad++;
      if (lg_data[fl0+i] != {16'h5AC3, 16'(16'h0104 + 4*i)}) bad++;
      if (lg_sa[sr0+i] != 16'(16'h0104 + 4*i)) bad++;
    end
    chk(bad == 0 && !got_err, "R3", "row addr/data order", bad, 0);
    chk(bad == 0, "R12", "start while busy ignored", fl_n - fl0, 128);
    @(negedge clk);
    chk(sleep_grant === 1'b1, "R12", "sleep granted when idle", {63'd0, sleep_grant}, 1);
    sleep_req = 1'b0;
  endtask

  task automatic t_page();
    wp_prog = 16'h0020;
    run_op(4'd4, 20'h03ABC, 32'h0, '0);
    chk(fl_n - fl0 == 1 && lg_er[fl0] && lg_addr[fl0] == 18'h0C00 && !got_err,
        "R4", "page erase base", lg_addr[fl0], 18'h0C00);
    wp_prog = 16'h0008;
    run_op(4'd4, 20'h03000, 32'h0, '0);
    chk(fl_n - fl0 == 0 && sr_n == sr0 && got_err, "R7", "protected page refused",
        fl_n - fl0, 0);
    wp_prog = '0;
  endtask

  task automatic t_area();
    int bad;
    wp_prog = 16'h0200;
    run_op(4'd5, 20'h85000, 32'h0, '0);
    chk(fl_n - fl0 == 0 && got_err, "R5", "area erase refused", fl_n - fl0, 0);
    wp_prog = '0; wp_boot = 1'b1;
    run_op(4'd5, 20'h85000, 32'h0, '0);
    bad = 0;
    for (int p = 0; p < 16; p++)
      if (lg_addr[fl0+p] != FA_W'(p << 10) || !lg_er[fl0+p]) bad++;
    chk(fl_n - fl0 == 16 && bad == 0 && !got_err, "R5", "area erase pages", fl_n - fl0, 16);
    chk(hold_n > 0 && hold_bad == 0, "R11", "payload held under back-pressure", hold_bad, 0);
  endtask

  task automatic t_boot();
    wp_boot = 1'b1;
    run_op(4'd1, 20'h80010, 32'h1, '0);
    chk(fl_n - fl0 == 0 && got_err, "R6", "boot page protected", fl_n - fl0, 0);
    wp_boot = 1'b0;
    run_op(4'd1, 20'h80010, 32'h2, '0);
    chk(fl_n - fl0 == 1 && !got_err && lg_addr[fl0] == 18'h20004, "R6", "boot page open",
        lg_addr[fl0], 18'h20004);
    run_op(4'd1, 20'h40000, 32'h3, '0);
    chk(fl_n - fl0 == 0 && got_err, "R6", "out-of-range page refused", fl_n - fl0, 0);
  endtask

  task automatic t_nop();
    run_op(4'd0, 20'h00000, 32'h0, '0);
    chk(fl_n - fl0 == 0 && sr_n == sr0 && !got_err && !got_lv, "R8", "nop clears error",
        {got_err, got_lv}, 0);
    run_op(4'd7, 20'h00000, 32'h0, '0);
    chk(fl_n - fl0 == 0 && !got_err, "R8", "unused code is nop", fl_n - fl0, 0);
  endtask

  task automatic t_lv();
    fork
      run_op(4'd3, 20'h04000, 32'h0, 16'h0200);
      begin
        int g;
        g = 0;
        @(negedge clk);
        while ((fl_n - fl0) < 3 && g < 5000) begin @(negedge clk); g++; end
        low_volt = 1'b1;
        @(negedge clk);
        low_volt = 1'b0;
      end
    join
    chk(got_lv && got_err, "R9", "low-voltage flags", {got_lv, got_err}, 3);
    chk(fl_n - fl0 >= 3 && fl_n - fl0 <= 5, "R9", "commands stop", fl_n - fl0, 4);
    run_op(4'd0, 20'h0, 32'h0, '0);
    chk(!got_lv && !got_err, "R8", "nop clears lv error", {got_lv, got_err}, 0);
  endtask

  bit timed_out = 0;
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_word();
        t_row();
        t_page();
        t_area();
        t_boot();
        t_nop();
        t_lv();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule